// File: doc/BRIEF.md
# Smart Card Clock and Bit-Period Generator

This block turns a fast peripheral clock into the clock pin of an ISO 7816-style smart card. It also provides the timing of one elementary time unit (etu), which is the bit period on the card line. The card clock is the peripheral clock divided by twice the programmed divisor plus one. Each etu spans a programmable number of full card-clock periods. The block raises a one-cycle tick when each etu ends and a one-cycle sample strobe near its middle. A character engine placed beside it uses these two pulses to shift and sample bits.

Configuration arrives through two plain write strobes. The timing write carries four fields together: divisor, etu length, clock-pin enable and self-check (loopback). The direction write carries the transmit and receive enables. After every accepted timing write, the block holds its ready output low until one full etu has elapsed with the new settings. Direction enables are granted only while ready is high. Transmit and receive may be on at the same time only in self-check mode. Timing fields cannot be changed while a direction is enabled. There is no data stream at this block's edge, so all pins are plain control and status signals without valid/ready handshakes.

Top module: `scclk_etu_gen`

## Requirements
- R1: After reset or an accepted timing write, the internal card clock starts low and toggles every divisor+1 peripheral cycles. This gives a period of 2×(divisor+1) cycles and a 50% duty cycle.
- R2: `card_clk_o` follows the internal card clock while the clock-pin enable in effect is 1, and is held at 0 while it is 0.
- R3: `etu_tick` is a one-cycle pulse at the end of every (etu_len+1)-th card-clock period. The first pulse comes exactly 2×(etu_len+1)×(divisor+1) cycles after the restart.
- R4: `etu_sample` is a one-cycle pulse at the end of the card-clock period whose zero-based index within the etu equals floor(etu_len/2).
- R5: `link_ready` is 0 after reset and after every accepted timing write. It rises together with the first `etu_tick` that follows, and then stays high.
- R6: A direction write sets `tx_en`/`rx_en` to the requested bits only if `link_ready` was high before the write and no timing write is accepted in the same cycle. Otherwise both enables go to 0.
- R7: A direction write may not switch to a different non-zero direction while an enable is on. Such a write clears both enables.
- R8: Requesting transmit and receive together while self-check is off leaves both enables at 0 and sets `cfg_err` to 1. Every direction write reloads `cfg_err` with this conflict condition.
- R9: With self-check on, transmit and receive may both be enabled. `loopback` shows the self-check setting in effect.
- R10: A timing write is ignored while `tx_en` or `rx_en` is 1. The clock, the etu timing and `link_ready` continue without a break.
- R11: While reset is held, and just after its release, the outputs `card_clk_o`, `etu_tick`, `etu_sample`, `link_ready`, `tx_en`, `rx_en`, `loopback` and `cfg_err` are all 0. The defaults in effect are divisor 7, etu length 371 and clock pin disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_wr | input | 1 | Timing write strobe |
| cfg_div | input | DIV_W | Card-clock divisor |
| cfg_etu_len | input | ETU_W | Card-clock periods per etu, minus one |
| cfg_clk_pin_en | input | 1 | Drive the card clock onto the pin |
| cfg_selfchk | input | 1 | Self-check (loopback) mode |
| dir_wr | input | 1 | Direction write strobe |
| cfg_tx | input | 1 | Transmit enable request |
| cfg_rx | input | 1 | Receive enable request |
| card_clk_o | output | 1 | Card clock pin |
| etu_tick | output | 1 | End-of-etu pulse |
| etu_sample | output | 1 | Mid-etu sample pulse |
| link_ready | output | 1 | Settling wait complete |
| tx_en | output | 1 | Transmit enabled |
| rx_en | output | 1 | Receive enabled |
| loopback | output | 1 | Self-check in effect |
| cfg_err | output | 1 | Rejected direction conflict |

## Verification
The assertions assume only that reset is applied before the first write. Strobes and request bits may take any value in any cycle, including requests while not ready and conflicting pairs. The stimulus drives both strobes and request bits from the falling clock edge, one write per cycle. It covers idle stretches of several etus, writes before and after ready, and divisor and etu-length values down to zero. Every output is compared against a period-counting model on each cycle.

// File: rtl/scetu_pkg.sv
`timescale 1ns/1ps
package scetu_pkg;
  typedef enum logic [1:0] {
    DIR_OFF  = 2'b00,
    DIR_TX   = 2'b01,
    DIR_RX   = 2'b10,
    DIR_BOTH = 2'b11
  } dir_e;
endpackage

// File: rtl/scetu_clkdiv.sv
`timescale 1ns/1ps
module scetu_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             sck,
  output logic             fall_ev
);
  logic [DIV_W-1:0] cnt;
  logic             hit;

  assign hit     = (cnt == div);
  // card clock will drop at the next edge: one card-clock period ends
  assign fall_ev = hit & sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (restart) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (hit) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/scetu_etucnt.sv
`timescale 1ns/1ps
module scetu_etucnt #(
  parameter int ETU_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             fall_ev,
  input  logic [ETU_W-1:0] etu_len,
  output logic             wrap_ev,
  output logic             tick,
  output logic             sample
);
  logic [ETU_W-1:0] pcnt;
  logic [ETU_W-1:0] half;
  logic             mid_ev;

  assign half    = etu_len >> 1;
  assign wrap_ev = fall_ev && (pcnt == etu_len);
  assign mid_ev  = fall_ev && (pcnt == half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt   <= '0;
      tick   <= 1'b0;
      sample <= 1'b0;
    end else if (restart) begin
      pcnt   <= '0;
      tick   <= 1'b0;
      sample <= 1'b0;
    end else begin
      tick   <= wrap_ev;
      sample <= mid_ev;
      if (fall_ev) pcnt <= wrap_ev ? '0 : pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/scetu_ctrl.sv
`timescale 1ns/1ps
module scetu_ctrl
  import scetu_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int ETU_W   = 11,
  parameter int RST_DIV = 7,
  parameter int RST_ETU = 371
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             time_wr,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [ETU_W-1:0] cfg_etu_len,
  input  logic             cfg_clk_pin_en,
  input  logic             cfg_selfchk,
  input  logic             dir_wr,
  input  logic             cfg_tx,
  input  logic             cfg_rx,
  input  logic             wrap_ev,
  output logic [DIV_W-1:0] div_q,
  output logic [ETU_W-1:0] etu_q,
  output logic             pin_en_q,
  output logic             self_q,
  output logic             restart,
  output logic             ready_q,
  output logic             tx_q,
  output logic             rx_q,
  output logic             err_q
);
  localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(RST_DIV);
  localparam logic [ETU_W-1:0] ETU_INIT = ETU_W'(RST_ETU);

  dir_e cur_dir, req_dir, nxt_dir;
  logic busy, self_eff, conflict, allow, same_or_off;

  assign cur_dir     = dir_e'({rx_q, tx_q});
  assign req_dir     = dir_e'({cfg_rx, cfg_tx});
  assign busy        = (cur_dir != DIR_OFF);
  assign restart     = time_wr & ~busy;
  assign self_eff    = restart ? cfg_selfchk : self_q;
  assign conflict    = (req_dir == DIR_BOTH) & ~self_eff;
  assign allow       = ready_q & ~restart;
  assign same_or_off = ~busy | (req_dir == cur_dir);

  always_comb begin
    nxt_dir = DIR_OFF;
    if (allow && !conflict && same_or_off) nxt_dir = req_dir;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= DIV_INIT;
      etu_q    <= ETU_INIT;
      pin_en_q <= 1'b0;
      self_q   <= 1'b0;
      ready_q  <= 1'b0;
      tx_q     <= 1'b0;
      rx_q     <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (restart) begin
        div_q    <= cfg_div;
        etu_q    <= cfg_etu_len;
        pin_en_q <= cfg_clk_pin_en;
        self_q   <= cfg_selfchk;
        ready_q  <= 1'b0;
      end else if (wrap_ev) begin
        ready_q  <= 1'b1;
      end
      if (dir_wr) begin
        tx_q  <= nxt_dir[0];
        rx_q  <= nxt_dir[1];
        err_q <= conflict;
      end
    end
  end
endmodule

// File: rtl/scclk_etu_gen.sv
`timescale 1ns/1ps
module scclk_etu_gen #(
  parameter int DIV_W   = 8,
  parameter int ETU_W   = 11,
  parameter int RST_DIV = 7,
  parameter int RST_ETU = 371
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             time_wr,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [ETU_W-1:0] cfg_etu_len,
  input  logic             cfg_clk_pin_en,
  input  logic             cfg_selfchk,
  input  logic             dir_wr,
  input  logic             cfg_tx,
  input  logic             cfg_rx,
  output logic             card_clk_o,
  output logic             etu_tick,
  output logic             etu_sample,
  output logic             link_ready,
  output logic             tx_en,
  output logic             rx_en,
  output logic             loopback,
  output logic             cfg_err
);
  logic [DIV_W-1:0] div_q;
  logic [ETU_W-1:0] etu_q;
  logic pin_en_q, self_q, restart, sck, fall_ev, wrap_ev;

  scetu_ctrl #(
    .DIV_W(DIV_W), .ETU_W(ETU_W), .RST_DIV(RST_DIV), .RST_ETU(RST_ETU)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .time_wr(time_wr), .cfg_div(cfg_div), .cfg_etu_len(cfg_etu_len),
    .cfg_clk_pin_en(cfg_clk_pin_en), .cfg_selfchk(cfg_selfchk),
    .dir_wr(dir_wr), .cfg_tx(cfg_tx), .cfg_rx(cfg_rx),
    .wrap_ev(wrap_ev),
    .div_q(div_q), .etu_q(etu_q), .pin_en_q(pin_en_q), .self_q(self_q),
    .restart(restart), .ready_q(link_ready),
    .tx_q(tx_en), .rx_q(rx_en), .err_q(cfg_err)
  );

  scetu_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .restart(restart), .div(div_q),
    .sck(sck), .fall_ev(fall_ev)
  );

  scetu_etucnt #(.ETU_W(ETU_W)) u_etu (
    .clk(clk), .rst_n(rst_n), .restart(restart), .fall_ev(fall_ev),
    .etu_len(etu_q), .wrap_ev(wrap_ev), .tick(etu_tick), .sample(etu_sample)
  );

  assign card_clk_o = sck & pin_en_q;
  assign loopback   = self_q;
endmodule

// File: rtl/scetu_checker.sv
`timescale 1ns/1ps
module scetu_checker (
  input logic clk,
  input logic rst_n,
  input logic dir_wr,
  input logic etu_tick,
  input logic etu_sample,
  input logic link_ready,
  input logic tx_en,
  input logic rx_en,
  input logic loopback,
  input logic cfg_err
);
  // R3: end-of-etu pulse lasts one cycle
  p_tick_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    etu_tick |=> !etu_tick);
  // R4: sample pulse lasts one cycle
  p_sample_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    etu_sample |=> !etu_sample);
  // R5: ready only rises on an etu boundary
  p_ready_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_ready) |-> etu_tick);
  // R6: an enable is never on without ready
  p_en_needs_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en || rx_en) |-> link_ready);
  // R6: enables move only on a direction write
  p_en_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_wr |=> ($stable(tx_en) && $stable(rx_en)));
  // R8: a flagged conflict leaves both enables off
  p_err_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!tx_en && !rx_en));
  // R9: both directions together only in self-check
  p_both_selfchk_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && rx_en) |-> loopback);
endmodule

bind scclk_etu_gen scetu_checker u_chk (
  .clk(clk), .rst_n(rst_n), .dir_wr(dir_wr),
  .etu_tick(etu_tick), .etu_sample(etu_sample), .link_ready(link_ready),
  .tx_en(tx_en), .rx_en(rx_en), .loopback(loopback), .cfg_err(cfg_err)
);

// File: tb/scclk_etu_gen_bench.sv
`timescale 1ns/1ps
module scclk_etu_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic time_wr = 1'b0, dir_wr = 1'b0;
  logic [7:0]  cfg_div = 8'd0;
  logic [10:0] cfg_etu_len = 11'd0;
  logic cfg_clk_pin_en = 1'b0, cfg_selfchk = 1'b0, cfg_tx = 1'b0, cfg_rx = 1'b0;
  logic card_clk_o, etu_tick, etu_sample, link_ready, tx_en, rx_en, loopback, cfg_err;

  int checks = 0;
  int failures = 0;

  // behavioural reference state
  int  m_div = 7, m_etu = 371, n = 0;
  bit  m_pin = 0, m_self = 0, m_ready = 0, m_tx = 0, m_rx = 0, m_err = 0;

  always #4 clk = ~clk;

  scclk_etu_gen u_scclk_etu_gen (
    .clk(clk), .rst_n(rst_n), .time_wr(time_wr), .cfg_div(cfg_div),
    .cfg_etu_len(cfg_etu_len), .cfg_clk_pin_en(cfg_clk_pin_en),
    .cfg_selfchk(cfg_selfchk), .dir_wr(dir_wr), .cfg_tx(cfg_tx), .cfg_rx(cfg_rx),
    .card_clk_o(card_clk_o), .etu_tick(etu_tick), .etu_sample(etu_sample),
    .link_ready(link_ready), .tx_en(tx_en), .rx_en(rx_en),
    .loopback(loopback), .cfg_err(cfg_err)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  function automatic bit e_tick(int k);
    int p = 2 * (m_div + 1);
    return (k > 0) && (k % p == 0) && (((k / p) % (m_etu + 1)) == 0);
  endfunction

  function automatic bit e_sample(int k);
    int p = 2 * (m_div + 1);
    return (k > 0) && (k % p == 0) && ((((k / p) - 1) % (m_etu + 1)) == m_etu / 2);
  endfunction

  task automatic compare_all();
    bit sck = ((n / (m_div + 1)) % 2) == 1;
    check("R1 R2 card_clk_o", card_clk_o, int'(sck && m_pin));
    check("R3 etu_tick", etu_tick, int'(e_tick(n)));
    check("R4 etu_sample", etu_sample, int'(e_sample(n)));
    check("R5 link_ready", link_ready, int'(m_ready));
    check("R6 R7 tx_en", tx_en, int'(m_tx));
    check("R6 R7 rx_en", rx_en, int'(m_rx));
    check("R9 loopback", loopback, int'(m_self));
    check("R8 cfg_err", cfg_err, int'(m_err));
  endtask

  // one clock: model advances, inputs applied, outputs compared at negedge
  task automatic step(bit tw, bit dw);
    bit acc, self_eff, conflict, allow, same_or_off, busy;
    busy = m_tx || m_rx;
    acc = tw && !busy;
    self_eff = acc ? cfg_selfchk : m_self;
    if (dw) begin
      conflict = cfg_tx && cfg_rx && !self_eff;
      allow = m_ready && !acc;
      same_or_off = !busy || (cfg_tx == m_tx && cfg_rx == m_rx);
      m_tx = cfg_tx && allow && !conflict && same_or_off;
      m_rx = cfg_rx && allow && !conflict && same_or_off;
      m_err = conflict;
    end
    if (acc) begin
      m_div = cfg_div; m_etu = cfg_etu_len; m_pin = cfg_clk_pin_en; m_self = cfg_selfchk;
      m_ready = 0; n = 0;
    end else begin
      n++;
      if (e_tick(n)) m_ready = 1;
    end
    time_wr = tw; dir_wr = dw;
    @(posedge clk);
    @(negedge clk);
    time_wr = 1'b0; dir_wr = 1'b0;
    compare_all();
  endtask

  task automatic idle(int cycles);
    for (int i = 0; i < cycles; i++) step(0, 0);
  endtask

  task automatic timing_write(int d, int e, bit pin, bit sc);
    cfg_div = 8'(d); cfg_etu_len = 11'(e); cfg_clk_pin_en = pin; cfg_selfchk = sc;
    step(1, 0);
  endtask

  task automatic dir_write(bit t, bit r);
    cfg_tx = t; cfg_rx = r;
    step(0, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R11: outputs idle while reset is held
    check("R11 reset ready", link_ready, 0);
    check("R11 reset tx", tx_en, 0);
    check("R11 reset pin", card_clk_o, 0);
    rst_n = 1'b1;
    n = 0;
    compare_all();
    // defaults: 7 / 371, pin off; ready after one full etu (R5, R11, R2)
    idle(2 * 8 * 372 - 1);
    check("R11 R5 not ready before one etu", link_ready, 0);
    idle(1);
    check("R11 R5 ready after one etu", link_ready, 1);
    idle(40);

    // small timing, pin on (R1 R2 R3 R4), enable request before ready (R6)
    timing_write(1, 4, 1, 0);
    dir_write(1, 0);
    check("R6 tx refused before ready", tx_en, 0);
    idle(30);
    dir_write(1, 0);
    check("R6 tx granted", tx_en, 1);
    idle(17);
    // R10: timing write while enabled is ignored
    timing_write(3, 2, 0, 1);
    check("R10 ready kept after ignored write", link_ready, 1);
    check("R10 loopback unchanged", loopback, 0);
    idle(45);
    // R7: switching direction while on clears both
    dir_write(0, 1);
    check("R7 switch clears rx", rx_en, 0);
    dir_write(0, 1);
    check("R6 rx granted", rx_en, 1);
    idle(9);
    dir_write(1, 1);
    check("R7 R8 conflict err", cfg_err, 1);
    dir_write(0, 0);
    check("R8 err reloaded", cfg_err, 0);

    // self-check with the smallest timing (R9)
    timing_write(0, 0, 1, 1);
    dir_write(1, 1);
    idle(3);
    dir_write(1, 1);
    check("R9 both enabled tx", tx_en, 1);
    check("R9 both enabled rx", rx_en, 1);
    idle(12);
    dir_write(0, 0);

    // pin disabled, odd etu length (R2 R4)
    timing_write(2, 5, 0, 0);
    idle(80);
    // timing write and direction write in the same cycle (R6)
    cfg_div = 8'd1; cfg_etu_len = 11'd3; cfg_clk_pin_en = 1'b1; cfg_selfchk = 1'b0;
    cfg_tx = 1'b1; cfg_rx = 1'b0;
    step(1, 1);
    check("R6 same-cycle restart refuses tx", tx_en, 0);
    idle(60);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule